// File: doc/BRIEF.md
# Bit-Plane Grayscale Time-Slice Scheduler

This block sets the timing for showing 8-bit colour values as 256 grey levels on an LED array. It shows each bit of the value as a separate plane for a time that matches the bit's weight. The base time unit is a sub-slot, one sixteenth of a line period. An external pulse `tick` marks the end of each sub-slot. Every plane gets an update interval made of whole line periods. During that interval the display enable is on for 2^p sub-slots, where p is the bit index. Planes whose lit time is shorter than one line period are blanked for the rest of their single line period.

The planes run from the most significant bit (plane 7) down to plane 0, then the sequence starts again. At the start of each plane interval the block issues a one-clock load strobe and the plane index, so the data path can fetch the matching bit of every pixel. A frame-start pulse marks each new pass through the planes.

Successive ticks must be at least two clocks apart.

Top module: `grayscale_scheduler`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `plane_idx` = 7, `disp_en` = 0, `plane_load` = 0 and `frame_start` = 0.
- R2: In the first clock after `rst` is released, `plane_load` and `frame_start` are both 1 and `plane_idx` is 7. Both are 0 in the clock after that.
- R3: Plane indices follow the order 7, 6, 5, 4, 3, 2, 1, 0, 7, and so on. `plane_idx` changes only in a clock where `plane_load` is 1.
- R4: A plane interval lasts max(16, 2^p) ticks: 16 ticks for planes 0 to 4, 32 for plane 5, 64 for plane 6 and 128 for plane 7. The next `plane_load` appears in the clock after the last tick of the interval.
- R5: Within a plane interval, `disp_en` is 1 at exactly the first 2^p ticks. It rises in the clock after `plane_load`.
- R6: Planes 0 to 3 are blanked (`disp_en` = 0) for the remaining 16 − 2^p ticks of their one-line interval.
- R7: `plane_load` is never high for two clocks in a row, and `disp_en` is 0 whenever `plane_load` is 1.
- R8: `frame_start` is 1 only together with a `plane_load` for plane 7. It appears when the sequence wraps from plane 0 and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse that ends each sub-slot (16 per line period) |
| plane_idx | output | 3 | Bit plane currently shown |
| plane_load | output | 1 | One-clock strobe at the start of each plane interval |
| disp_en | output | 1 | Display enable (1 = lit, 0 = blanked) |
| frame_start | output | 1 | One-clock pulse when plane 7 begins |

## Verification
The hardest corner to reach is the boundary after a fully lit plane such as 4 or 7. There the lit window runs to the end of the interval, and the enable must still drop for the load clock before the next plane starts. The stimulus covers this by running complete frames at three tick spacings. A scoreboard counts lit and blanked ticks per plane, so a lit window that runs one tick long or short shows up at every one of those boundaries. A reset in the middle of a plane interval, followed by a new frame, covers restart from a part-finished state.

// File: rtl/gs_sched_pkg.sv
package gs_sched_pkg;

    // Sub-slots lit for bit plane p: weight doubles per bit, LSB lit for one sub-slot.
    function automatic int unsigned gs_lit_ticks(input int unsigned plane);
        return 32'd1 << plane;
    endfunction

    // Sub-slots in a plane interval: whole line periods, at least one line.
    function automatic int unsigned gs_slot_ticks(input int unsigned plane,
                                                  input int unsigned subs);
        int unsigned lit;
        lit = gs_lit_ticks(plane);
        return (lit < subs) ? subs : lit;
    endfunction

    function automatic int unsigned gs_max_slot(input int unsigned planes,
                                                input int unsigned subs);
        return gs_slot_ticks(planes - 1, subs);
    endfunction

endpackage

// File: rtl/gs_slot_timer.sv
module gs_slot_timer
    import gs_sched_pkg::*;
#(
    parameter int PLANES = 8,
    parameter int SUBS   = 16,
    parameter int PW     = 3,
    parameter int SW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold,
    input  logic [PW-1:0] plane_q_i,
    output logic [SW-1:0] sub_q_o,
    output logic [SW-1:0] sub_d_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [SW-1:0] sub;
    } timer_t;

    timer_t        st_d, st_q;
    logic [SW-1:0] last_tab [PLANES];
    logic          at_last;

    for (genvar g = 0; g < PLANES; g++) begin : g_last
        assign last_tab[g] = SW'(gs_slot_ticks(g, SUBS) - 1);
    end

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.sub == last_tab[plane_q_i]);
        wrap_o  = tick && !hold && at_last;
        if (rst) begin
            st_d.sub = '0;
        end else if (tick && !hold) begin
            st_d.sub = at_last ? '0 : st_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sub_q_o = st_q.sub;
    assign sub_d_o = st_d.sub;

    assert_sub_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.sub <= last_tab[plane_q_i]);

    assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (st_q.sub == '0));

endmodule

// File: rtl/gs_plane_seq.sv
module gs_plane_seq #(
    parameter int PLANES = 8,
    parameter int PW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    output logic [PW-1:0] plane_q_o,
    output logic [PW-1:0] plane_d_o,
    output logic          load_q_o,
    output logic          load_d_o,
    output logic          frame_q_o,
    output logic          hold_o
);

    localparam logic [PW-1:0] TOP_PLANE = PW'(PLANES - 1);

    typedef struct packed {
        logic [PW-1:0] plane;
        logic          load;
        logic          frame;
        logic          pend;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.load  = 1'b0;
        st_d.frame = 1'b0;
        if (rst) begin
            st_d.plane = TOP_PLANE;
            st_d.pend  = 1'b1;
        end else if (st_q.pend) begin
            st_d.pend  = 1'b0;
            st_d.load  = 1'b1;
            st_d.frame = 1'b1;
        end else if (wrap) begin
            st_d.load = 1'b1;
            if (st_q.plane == '0) begin
                st_d.plane = TOP_PLANE;
                st_d.frame = 1'b1;
            end else begin
                st_d.plane = st_q.plane - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign plane_q_o = st_q.plane;
    assign plane_d_o = st_d.plane;
    assign load_q_o  = st_q.load;
    assign load_d_o  = st_d.load;
    assign frame_q_o = st_q.frame;
    assign hold_o    = st_q.pend;

    assert_load_single_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.load |=> !st_q.load);

    assert_frame_on_top_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.frame |-> (st_q.load && st_q.plane == TOP_PLANE));

    assert_plane_step_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.load && !st_q.frame) |-> (st_q.plane == $past(st_q.plane) - 1'b1));

    assert_plane_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.plane) |-> st_q.load);

endmodule

// File: rtl/gs_window.sv
module gs_window
    import gs_sched_pkg::*;
#(
    parameter int PLANES = 8,
    parameter int PW     = 3,
    parameter int SW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          load_d_i,
    input  logic          load_q_i,
    input  logic [PW-1:0] plane_d_i,
    input  logic [PW-1:0] plane_q_i,
    input  logic [SW-1:0] sub_d_i,
    input  logic [SW-1:0] sub_q_i,
    output logic          en_q_o
);

    typedef struct packed {
        logic en;
    } win_t;

    win_t          st_d, st_q;
    logic [SW-1:0] lit_tab [PLANES];

    for (genvar g = 0; g < PLANES; g++) begin : g_lit
        assign lit_tab[g] = SW'(gs_lit_ticks(g));
    end

    always_comb begin
        st_d.en = !rst && !load_d_i && (sub_d_i < lit_tab[plane_d_i]);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_q_o = st_q.en;

    assert_lit_bounds_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.en |-> (sub_q_i < lit_tab[plane_q_i]));

    assert_lit_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_q_i && sub_q_i < lit_tab[plane_q_i]) |-> st_q.en);

endmodule

// File: rtl/grayscale_scheduler.sv
module grayscale_scheduler
    import gs_sched_pkg::*;
#(
    parameter int PLANES        = 8,
    parameter int SUBS_PER_LINE = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    output logic [$clog2(PLANES)-1:0] plane_idx,
    output logic                      plane_load,
    output logic                      disp_en,
    output logic                      frame_start
);

    localparam int PW = $clog2(PLANES);
    localparam int SW = $clog2(gs_max_slot(PLANES, SUBS_PER_LINE) + 1);

    logic [PW-1:0] plane_q, plane_d;
    logic [SW-1:0] sub_q, sub_d;
    logic          load_q, load_d, frame_q, hold, wrap, en_q;

    gs_slot_timer #(.PLANES(PLANES), .SUBS(SUBS_PER_LINE), .PW(PW), .SW(SW)) timer_i (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold), .plane_q_i(plane_q),
        .sub_q_o(sub_q), .sub_d_o(sub_d), .wrap_o(wrap)
    );

    gs_plane_seq #(.PLANES(PLANES), .PW(PW)) seq_i (
        .clk(clk), .rst(rst), .wrap(wrap),
        .plane_q_o(plane_q), .plane_d_o(plane_d), .load_q_o(load_q), .load_d_o(load_d),
        .frame_q_o(frame_q), .hold_o(hold)
    );

    gs_window #(.PLANES(PLANES), .PW(PW), .SW(SW)) win_i (
        .clk(clk), .rst(rst), .hold(hold), .load_d_i(load_d), .load_q_i(load_q),
        .plane_d_i(plane_d), .plane_q_i(plane_q), .sub_d_i(sub_d), .sub_q_i(sub_q),
        .en_q_o(en_q)
    );

    assign plane_idx   = plane_q;
    assign plane_load  = load_q;
    assign disp_en     = en_q;
    assign frame_start = frame_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (plane_idx == PW'(PLANES - 1) && !disp_en && !plane_load && !frame_start));

    assert_start_after_reset_R2: assert property (@(posedge clk)
        $fell(rst) |=> (plane_load && frame_start));

    assert_blank_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        plane_load |-> !disp_en);

endmodule

// File: tb/grayscale_scheduler_tb_top.sv
module grayscale_scheduler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PLANES     = 8;
    localparam int SUBS       = 16;

    typedef struct {
        int plane;
        bit frame;
        int ticks;
        int lit;
    } slot_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] plane_idx;
    logic       plane_load, disp_en, frame_start;

    int    checks = 0;
    int    errors = 0;
    int    exp_plane = PLANES - 1;
    slot_t exp_q[$];

    bit active = 0, after_load = 0, prev_load = 0, cur_frame = 0;
    int cur_plane = 0, cnt = 0, lit_cnt = 0;

    grayscale_scheduler #(.PLANES(PLANES), .SUBS_PER_LINE(SUBS)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .plane_idx(plane_idx),
        .plane_load(plane_load), .disp_en(disp_en), .frame_start(frame_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int slot_len(int p);
        int lit;
        lit = 1 << p;
        return (lit < SUBS) ? SUBS : lit;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    // Driver: pushes the expected plane intervals, then produces their ticks.
    task automatic run_slots(int n, int gap);
        for (int i = 0; i < n; i++) begin
            slot_t s;
            s.plane = exp_plane;
            s.frame = (exp_plane == PLANES - 1);
            s.ticks = slot_len(exp_plane);
            s.lit   = 1 << exp_plane;
            exp_q.push_back(s);
            send_ticks(s.ticks, gap);
            exp_plane = (exp_plane == 0) ? PLANES - 1 : exp_plane - 1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        exp_q.delete();
        exp_plane = PLANES - 1;
        repeat (3) @(negedge clk);
        check(plane_idx == 3'd7, "R1 plane in reset", plane_idx, 7);
        check(!disp_en && !plane_load && !frame_start, "R1 strobes in reset",
              {disp_en, plane_load, frame_start}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(plane_load && frame_start, "R2 start strobes", {plane_load, frame_start}, 3);
        check(plane_idx == 3'd7, "R2 start plane", plane_idx, 7);
        @(negedge clk);
        check(!plane_load && !frame_start, "R2 strobes drop", {plane_load, frame_start}, 0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: measures each plane interval at the ports and compares with the queue.
    always @(negedge clk) begin
        if (rst) begin
            active     = 0;
            after_load = 0;
            prev_load  = 0;
        end else begin
            if (plane_load) begin
                check(!disp_en, "R7 enable low during load", disp_en, 0);
                check(!prev_load, "R7 load width", prev_load, 0);
                if (active) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3 unexpected interval", cur_plane, -1);
                    end else begin
                        slot_t e;
                        e = exp_q.pop_front();
                        check(cur_plane == e.plane, "R3 plane order", cur_plane, e.plane);
                        check(cur_frame == e.frame, "R8 frame flag", cur_frame, e.frame);
                        check(cnt == e.ticks, "R4 interval ticks", cnt, e.ticks);
                        check(lit_cnt == e.lit, "R5 lit ticks", lit_cnt, e.lit);
                        check(cnt - lit_cnt == e.ticks - e.lit, "R6 blank ticks",
                              cnt - lit_cnt, e.ticks - e.lit);
                    end
                end
                cur_plane  = plane_idx;
                cur_frame  = frame_start;
                cnt        = 0;
                lit_cnt    = 0;
                active     = 1;
                after_load = 1;
            end else begin
                if (frame_start) check(0, "R8 frame without load", 1, 0);
                if (after_load) check(disp_en, "R5 enable rises after load", disp_en, 1);
                after_load = 0;
                if (active && plane_idx != cur_plane)
                    check(0, "R3 plane changed without load", plane_idx, cur_plane);
                if (active && tick) begin
                    cnt++;
                    if (disp_en) lit_cnt++;
                end
            end
            prev_load = plane_load;
        end
    end

    initial begin
        do_reset();
        run_slots(16, 2);
        run_slots(8, 3);
        run_slots(3, 5);
        send_ticks(7, 4);
        do_reset();
        run_slots(8, 2);
        check(exp_q.size() == 0, "R4 all intervals completed", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule